// File: doc/BRIEF.md
# 1-Wire slave bit transceiver

This block is the bit-level front end of a 1-Wire slave. It watches one open-drain data line through a synchronizer, and it can only pull that line low or release it. It recognises reset pulses from the master and answers each one with a presence pulse. Each master-initiated time slot is either decoded into a received bit or used to send one bit back. Command decoding and byte assembly are left to the layers above it. Bits travel least significant first, and the upper layer presents and collects them in that order.

The upper layer decides how each slot is used. If `tx_en` is high when a slot's falling edge is seen, the slot is a read slot and `tx_bit` is sent. Otherwise the slot is a write slot and the sampled level comes back on `rx_valid`/`rx_bit`. Two speed grades are supported. The upper layer raises `od_req` to enter overdrive. A long reset drops overdrive; a short one keeps it. All timing is derived from `CLK_HZ`, which must be a whole number of MHz.

Top module: `owl_bit_xcvr`

## Requirements
- R1: A low on the synchronized line lasting `RST_REG_US` (480 µs) at regular speed, or `RST_OD_US` (48 µs) in overdrive, is a reset. It raises `rst_evt` for exactly one cycle per low period, even when both thresholds are crossed, and aborts the slot in progress.
- R2: Once the line is high again after a reset, the block waits `GAP_*_US` (30 µs regular, 3 µs overdrive). It then asserts `line_pull` for `PRES_*_US` (120 µs regular, 12 µs overdrive) consecutive cycles.
- R3: In a write slot, the line level is sampled `SMP_*_US` (30 µs regular, 3 µs overdrive) after the synchronized falling edge. The sample appears on `rx_bit` (1 = line high) with a one-cycle `rx_valid`.
- R4: In a read slot with `tx_bit`=0, `line_pull` is held for exactly `RDV_*_US` (15 µs regular, 2 µs overdrive) and then released.
- R5: In a read slot with `tx_bit`=1, `line_pull` is never asserted. Every read slot gives one `tx_taken` pulse.
- R6: A one-cycle `od_req` while the line is high sets `od_mode` from the next cycle on. After reset, `od_mode` and `line_pull` are 0.
- R7: A low of `RST_REG_US` or longer clears `od_mode`. A reset of at most 80 µs in overdrive leaves it set.
- R8: The line passes two synchronizer flops. A read-0 slot's `line_pull` rises on the third rising clock edge after `line_in` falls, and every slot timer counts from that point.
- R9: A low shorter than the reset threshold produces no `rst_evt` and is handled as a write slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, frequency `CLK_HZ` |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Raw level of the shared data line (asynchronous) |
| line_pull | output | 1 | 1 = pull the data line low; 0 = release it |
| od_req | input | 1 | One-cycle request to enter overdrive speed |
| od_mode | output | 1 | 1 = overdrive timing in use |
| tx_en | input | 1 | Next slot is a read slot (block sends a bit) |
| tx_bit | input | 1 | Bit to send in a read slot |
| tx_taken | output | 1 | One-cycle pulse: a read slot consumed `tx_bit` |
| rx_valid | output | 1 | One-cycle pulse: `rx_bit` holds a received bit |
| rx_bit | output | 1 | Level sampled in the last write slot |
| rst_evt | output | 1 | One-cycle pulse: reset pulse detected |

## Verification
The assertions assume a master that follows the slot rules. Every low is either a slot shorter than the reset threshold with the line steady around the sample point, or a reset. The upper layer is assumed to raise `od_req` only while the line is high, and to hold `tx_en`/`tx_bit` steady from before a slot's falling edge until that slot ends. The stimulus drives the line only from whole-slot and whole-reset tasks with recovery gaps at least as long as the presence sequence. It pulses `od_req` only between slots.

// File: rtl/owl_pkg.sv
// Shared types and helpers for the 1-Wire slave bit transceiver.
// Assumes the clock is a whole number of MHz.
package owl_pkg;

    // Slot controller states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_WAIT_HI,
        ST_RST_LOW,
        ST_PRES_GAP,
        ST_PRES_LOW
    } slot_st_e;

    // Converts microseconds to clock cycles.
    function automatic int us_to_cyc(input int hz, input int us);
        return (hz / 1_000_000) * us;
    endfunction

endpackage

// File: rtl/owl_line_sync.sv
// Two-flop synchronizer for the data line, plus a falling-edge detector.
// Assumes the line idles high; every stage resets to 1 so no edge is seen at start-up.
module owl_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic lvl,
    output logic fell
);
    logic s1, s2, s3;

    // Moves the line through two metastability flops and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= line_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign lvl  = s2;
    assign fell = s3 & ~s2;
endmodule

// File: rtl/owl_reset_det.sv
// Measures each low period of the synchronized line and recognises reset pulses
// against the threshold of the current speed grade. Also keeps the overdrive flag,
// which a reset of regular length clears.
// Assumes od_req arrives only while the line is high.
module owl_reset_det #(
    parameter int RST_REG_C = 960,
    parameter int RST_OD_C  = 96,
    parameter int CW        = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic od_req,
    output logic rst_hit,
    output logic rst_evt,
    output logic od_mode
);
    localparam int LO_MAX = RST_REG_C + 1;

    logic [CW-1:0] lo_cnt;
    logic [CW-1:0] thr_m1;
    logic          od_clr;

    assign thr_m1  = od_mode ? CW'(RST_OD_C - 1) : CW'(RST_REG_C - 1);
    assign rst_hit = !lvl && (lo_cnt == thr_m1);
    assign od_clr  = !lvl && (lo_cnt == CW'(RST_REG_C - 1));

    // Counts low cycles, clears on high, and saturates just above the regular threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)                      lo_cnt <= '0;
        else if (lvl)                    lo_cnt <= '0;
        else if (lo_cnt != CW'(LO_MAX))  lo_cnt <= lo_cnt + 1'b1;
    end

    // Overdrive flag: a long reset clears it and takes priority over a request.
    always_ff @(posedge clk) begin
        if (!rst_n)      od_mode <= 1'b0;
        else if (od_clr) od_mode <= 1'b0;
        else if (od_req) od_mode <= 1'b1;
    end

    // Registers the one-cycle reset event for the upper layer.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_evt <= 1'b0;
        else        rst_evt <= rst_hit;
    end

    a_r1_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> !rst_evt);

    a_r7_od_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        $past(od_clr) |-> !od_mode);

    a_r6_od_entered: assert property (@(posedge clk) disable iff (!rst_n)
        $past(od_req && !od_clr) |-> od_mode);
endmodule

// File: rtl/owl_slot_ctrl.sv
// Slot and presence sequencer. Starts a slot timer on each synchronized falling
// edge, samples write slots, holds the line for read-0 slots, and drives the
// presence pulse after a reset.
// Assumes tx_en and tx_bit are steady when a slot begins. rst_hit overrides every state.
module owl_slot_ctrl
    import owl_pkg::*;
#(
    parameter int SMP_REG_C = 60,
    parameter int SMP_OD_C  = 6,
    parameter int RDV_REG_C = 30,
    parameter int RDV_OD_C  = 4,
    parameter int GAP_REG_C = 60,
    parameter int GAP_OD_C  = 6,
    parameter int PL_REG_C  = 240,
    parameter int PL_OD_C   = 24,
    parameter int TW        = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic fell,
    input  logic rst_hit,
    input  logic od_mode,
    input  logic tx_en,
    input  logic tx_bit,
    output logic line_pull,
    output logic tx_taken,
    output logic rx_valid,
    output logic rx_bit
);
    slot_st_e      st;
    logic [TW-1:0] tmr;
    logic          rd;
    logic          rd_one;
    logic [TW-1:0] smp_end, rdv_end, gap_end, pl_end;
    logic [TW-1:0] pull_run;

    assign smp_end = od_mode ? TW'(SMP_OD_C - 1) : TW'(SMP_REG_C - 1);
    assign rdv_end = od_mode ? TW'(RDV_OD_C - 1) : TW'(RDV_REG_C - 1);
    assign gap_end = od_mode ? TW'(GAP_OD_C - 1) : TW'(GAP_REG_C - 1);
    assign pl_end  = od_mode ? TW'(PL_OD_C - 1)  : TW'(PL_REG_C - 1);

    // State machine: slot timing, presence pulse, and upper-layer strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            tmr       <= '0;
            rd        <= 1'b0;
            rd_one    <= 1'b0;
            line_pull <= 1'b0;
            tx_taken  <= 1'b0;
            rx_valid  <= 1'b0;
            rx_bit    <= 1'b0;
        end else begin
            tx_taken <= 1'b0;
            rx_valid <= 1'b0;
            if (rst_hit) begin
                st        <= ST_RST_LOW;
                line_pull <= 1'b0;
            end else begin
                case (st)
                    ST_IDLE: begin
                        if (fell) begin
                            st        <= ST_SLOT;
                            tmr       <= '0;
                            rd        <= tx_en;
                            rd_one    <= tx_bit;
                            tx_taken  <= tx_en;
                            line_pull <= tx_en & ~tx_bit;
                        end
                    end
                    ST_SLOT: begin
                        if (rd) begin
                            if (tmr == rdv_end) begin
                                line_pull <= 1'b0;
                                st        <= ST_WAIT_HI;
                            end else begin
                                tmr <= tmr + 1'b1;
                            end
                        end else if (tmr == smp_end) begin
                            rx_valid <= 1'b1;
                            rx_bit   <= lvl;
                            st       <= ST_WAIT_HI;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                    ST_WAIT_HI: begin
                        if (lvl) st <= ST_IDLE;
                    end
                    ST_RST_LOW: begin
                        if (lvl) begin
                            st  <= ST_PRES_GAP;
                            tmr <= '0;
                        end
                    end
                    ST_PRES_GAP: begin
                        if (tmr == gap_end) begin
                            st        <= ST_PRES_LOW;
                            tmr       <= '0;
                            line_pull <= 1'b1;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                    ST_PRES_LOW: begin
                        if (tmr == pl_end) begin
                            line_pull <= 1'b0;
                            st        <= ST_WAIT_HI;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // Checker counter: length of the current run of pull-low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                           pull_run <= '0;
        else if (!line_pull)                  pull_run <= '0;
        else if (pull_run != TW'(PL_REG_C+1)) pull_run <= pull_run + 1'b1;
    end

    a_r2_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        pull_run <= TW'(PL_REG_C));

    a_r2_gap_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRES_GAP) |-> !line_pull);

    a_r3_write_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !line_pull);

    a_r5_one_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLOT && rd && rd_one) |-> !line_pull);
endmodule

// File: rtl/owl_bit_xcvr.sv
// Top of the 1-Wire slave bit transceiver. Converts microsecond timing into
// cycle counts and connects the synchronizer, reset detector and slot sequencer.
// Assumes CLK_HZ is a whole number of MHz and line_pull drives an open-drain pad.
module owl_bit_xcvr
    import owl_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int RST_REG_US  = 480,
    parameter int RST_OD_US   = 48,
    parameter int SMP_REG_US  = 30,
    parameter int SMP_OD_US   = 3,
    parameter int RDV_REG_US  = 15,
    parameter int RDV_OD_US   = 2,
    parameter int GAP_REG_US  = 30,
    parameter int GAP_OD_US   = 3,
    parameter int PRES_REG_US = 120,
    parameter int PRES_OD_US  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_pull,
    input  logic od_req,
    output logic od_mode,
    input  logic tx_en,
    input  logic tx_bit,
    output logic tx_taken,
    output logic rx_valid,
    output logic rx_bit,
    output logic rst_evt
);
    localparam int RST_REG_C = us_to_cyc(CLK_HZ, RST_REG_US);
    localparam int RST_OD_C  = us_to_cyc(CLK_HZ, RST_OD_US);
    localparam int SMP_REG_C = us_to_cyc(CLK_HZ, SMP_REG_US);
    localparam int SMP_OD_C  = us_to_cyc(CLK_HZ, SMP_OD_US);
    localparam int RDV_REG_C = us_to_cyc(CLK_HZ, RDV_REG_US);
    localparam int RDV_OD_C  = us_to_cyc(CLK_HZ, RDV_OD_US);
    localparam int GAP_REG_C = us_to_cyc(CLK_HZ, GAP_REG_US);
    localparam int GAP_OD_C  = us_to_cyc(CLK_HZ, GAP_OD_US);
    localparam int PL_REG_C  = us_to_cyc(CLK_HZ, PRES_REG_US);
    localparam int PL_OD_C   = us_to_cyc(CLK_HZ, PRES_OD_US);
    localparam int CW        = $clog2(RST_REG_C + 2);

    logic lvl, fell, rst_hit;

    owl_line_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .lvl     (lvl),
        .fell    (fell)
    );

    owl_reset_det #(
        .RST_REG_C (RST_REG_C),
        .RST_OD_C  (RST_OD_C),
        .CW        (CW)
    ) u_rdet (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .od_req  (od_req),
        .rst_hit (rst_hit),
        .rst_evt (rst_evt),
        .od_mode (od_mode)
    );

    owl_slot_ctrl #(
        .SMP_REG_C (SMP_REG_C),
        .SMP_OD_C  (SMP_OD_C),
        .RDV_REG_C (RDV_REG_C),
        .RDV_OD_C  (RDV_OD_C),
        .GAP_REG_C (GAP_REG_C),
        .GAP_OD_C  (GAP_OD_C),
        .PL_REG_C  (PL_REG_C),
        .PL_OD_C   (PL_OD_C),
        .TW        (CW)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .fell      (fell),
        .rst_hit   (rst_hit),
        .od_mode   (od_mode),
        .tx_en     (tx_en),
        .tx_bit    (tx_bit),
        .line_pull (line_pull),
        .tx_taken  (tx_taken),
        .rx_valid  (rx_valid),
        .rx_bit    (rx_bit)
    );
endmodule

// File: tb/sim_owl_bit_xcvr.sv
module sim_owl_bit_xcvr;
    // Bench runs the block at 2 cycles per microsecond of protocol time.
    localparam int CYC = 2;
    localparam int M_RST_REG = 480 * CYC, M_RST_OD = 48 * CYC;
    localparam int M_SMP_REG = 30 * CYC,  M_SMP_OD = 3 * CYC;
    localparam int M_RDV_REG = 15 * CYC,  M_RDV_OD = 2 * CYC;
    localparam int M_GAP_REG = 30 * CYC,  M_GAP_OD = 3 * CYC;
    localparam int M_PL_REG  = 120 * CYC, M_PL_OD  = 12 * CYC;

    logic clk = 1'b0;
    logic rst_n, m_low, od_req, tx_en, tx_bit;
    logic line_pull, od_mode, tx_taken, rx_valid, rx_bit, rst_evt;
    logic line;

    assign line = ~(m_low | line_pull);

    always #5 clk = ~clk;

    owl_bit_xcvr #(.CLK_HZ(CYC * 1_000_000)) u0 (
        .clk(clk), .rst_n(rst_n), .line_in(line), .line_pull(line_pull),
        .od_req(od_req), .od_mode(od_mode), .tx_en(tx_en), .tx_bit(tx_bit),
        .tx_taken(tx_taken), .rx_valid(rx_valid), .rx_bit(rx_bit), .rst_evt(rst_evt)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit q[$];
    bit e_pull, e_evt, e_rxv, e_rxb, e_take, e_od, m_rd, started;
    int ph, t, lo;   // ph: 0 idle 1 slot 2 wait-high 3 reset-low 4 gap 5 presence

    always @(posedge clk) begin
        if (!rst_n) begin
            q = '{1'b1, 1'b1, 1'b1};
            e_pull = 0; e_evt = 0; e_rxv = 0; e_rxb = 0; e_take = 0; e_od = 0;
            ph = 0; t = 0; lo = 0; m_rd = 0; started = 1;
        end else begin
            bit cur, prv, odo, hit, clr;
            int smp, rdv, gap, pl;
            cur = q[q.size()-2];
            prv = q[q.size()-3];
            odo = e_od;
            smp = odo ? M_SMP_OD : M_SMP_REG;
            rdv = odo ? M_RDV_OD : M_RDV_REG;
            gap = odo ? M_GAP_OD : M_GAP_REG;
            pl  = odo ? M_PL_OD  : M_PL_REG;
            hit = !cur && (lo == (odo ? M_RST_OD : M_RST_REG) - 1);
            clr = !cur && (lo == M_RST_REG - 1);
            e_evt = hit; e_rxv = 0; e_take = 0;
            if (clr) e_od = 0; else if (od_req) e_od = 1;
            if (cur) lo = 0; else if (lo != M_RST_REG + 1) lo++;
            if (hit) begin
                ph = 3; e_pull = 0;
            end else begin
                case (ph)
                    0: if (prv && !cur) begin
                           ph = 1; t = 0; m_rd = tx_en;
                           if (tx_en) begin e_take = 1; e_pull = !tx_bit; end
                       end
                    1: if (m_rd) begin
                           if (t == rdv - 1) begin e_pull = 0; ph = 2; end else t++;
                       end else if (t == smp - 1) begin
                           e_rxv = 1; e_rxb = cur; ph = 2;
                       end else t++;
                    2: if (cur) ph = 0;
                    3: if (cur) begin ph = 4; t = 0; end
                    4: if (t == gap - 1) begin ph = 5; t = 0; e_pull = 1; end else t++;
                    5: if (t == pl - 1) begin e_pull = 0; ph = 2; end else t++;
                    default: ph = 0;
                endcase
            end
            q.push_back(line);
            if (q.size() > 4) void'(q.pop_front());
        end
    end

    // Per-cycle comparison plus event counters for directed checks.
    int pull_cnt = 0, n_evt = 0, n_take = 0;
    bit rxq[$];
    always @(negedge clk) begin
        if (started && !done) begin
            chk(line_pull == e_pull, "R2 R4 R8 line_pull vs model", line_pull, e_pull);
            chk(rst_evt == e_evt, "R1 rst_evt vs model", rst_evt, e_evt);
            chk(od_mode == e_od, "R6 R7 od_mode vs model", od_mode, e_od);
            chk(tx_taken == e_take, "R5 tx_taken vs model", tx_taken, e_take);
            chk(rx_valid == e_rxv, "R3 rx_valid vs model", rx_valid, e_rxv);
            if (e_rxv) chk(rx_bit == e_rxb, "R3 rx_bit vs model", rx_bit, e_rxb);
        end
        pull_cnt += int'(line_pull);
        n_evt    += int'(rst_evt);
        n_take   += int'(tx_taken);
        if (rx_valid) rxq.push_back(rx_bit);
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_reset(input int low_cyc);
        pull_cnt = 0;
        m_low = 1; wait_n(low_cyc);
        m_low = 0; wait_n(360);
    endtask

    task automatic wr_slot(input bit b, input bit od);
        int lw, tot;
        tot = od ? 20 : 140;
        lw  = b ? 2 : (od ? 14 : 120);
        m_low = 1; wait_n(lw);
        m_low = 0; wait_n(tot - lw);
    endtask

    task automatic rd_slot(input bit b, input bit od);
        pull_cnt = 0;
        tx_en = 1; tx_bit = b; wait_n(1);
        m_low = 1; wait_n(2);
        m_low = 0; wait_n(od ? 20 : 140);
        tx_en = 0; wait_n(2);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit od, input string req);
        logic [7:0] got;
        rxq.delete();
        for (int i = 0; i < 8; i++) wr_slot(v[i], od);
        got = '0;
        for (int i = 0; i < 8 && i < rxq.size(); i++) got[i] = rxq[i];
        chk(rxq.size() == 8, req, rxq.size(), 8);
        chk(got == v, req, got, v);
    endtask

    initial begin
        int b0, tk, n;
        rst_n = 0; m_low = 0; od_req = 0; tx_en = 0; tx_bit = 0;
        wait_n(5); rst_n = 1; wait_n(3);
        chk(line_pull == 0, "R6 reset state line_pull", line_pull, 0);
        chk(od_mode == 0, "R6 reset state od_mode", od_mode, 0);
        chk(rst_evt == 0, "R1 reset state rst_evt", rst_evt, 0);

        // R1/R2: regular reset and presence
        b0 = n_evt; bus_reset(500 * CYC);
        chk(n_evt == b0 + 1, "R1 one event for regular reset", n_evt - b0, 1);
        chk(pull_cnt == M_PL_REG, "R2 regular presence length", pull_cnt, M_PL_REG);

        // R3: write slots, LSB first
        send_byte(8'hA5, 0, "R3 regular byte");

        // R4/R5: read slots
        tk = n_take;
        rd_slot(0, 0);
        chk(pull_cnt == M_RDV_REG, "R4 regular read-0 hold", pull_cnt, M_RDV_REG);
        rd_slot(1, 0);
        chk(pull_cnt == 0, "R5 regular read-1 no pull", pull_cnt, 0);
        chk(n_take == tk + 2, "R5 tx_taken per read slot", n_take - tk, 2);

        // R9: short low is a write-0 slot, not a reset
        b0 = n_evt; rxq.delete();
        m_low = 1; wait_n(100 * CYC); m_low = 0; wait_n(200);
        chk(n_evt == b0, "R9 short low no reset", n_evt - b0, 0);
        chk(rxq.size() == 1 && rxq[0] == 0, "R9 short low read as 0", rxq.size(), 1);

        // R8: pull rises on the third edge after the fall
        tx_en = 1; tx_bit = 0; wait_n(1);
        m_low = 1; n = 0;
        while (!line_pull && n < 10) begin
            wait_n(1); n++;
            if (n == 2) m_low = 0;
        end
        m_low = 0; wait_n(140); tx_en = 0; wait_n(2);
        chk(n == 3, "R8 synchronizer latency", n, 3);

        // R6: enter overdrive
        od_req = 1; wait_n(1); od_req = 0; wait_n(2);
        chk(od_mode == 1, "R6 overdrive entered", od_mode, 1);

        // R7: short overdrive reset keeps overdrive
        b0 = n_evt; bus_reset(60 * CYC);
        chk(n_evt == b0 + 1, "R1 overdrive reset event", n_evt - b0, 1);
        chk(od_mode == 1, "R7 overdrive kept by short reset", od_mode, 1);
        chk(pull_cnt == M_PL_OD, "R2 overdrive presence length", pull_cnt, M_PL_OD);

        send_byte(8'h3C, 1, "R3 overdrive byte");
        rd_slot(0, 1);
        chk(pull_cnt == M_RDV_OD, "R4 overdrive read-0 hold", pull_cnt, M_RDV_OD);
        rd_slot(1, 1);
        chk(pull_cnt == 0, "R5 overdrive read-1 no pull", pull_cnt, 0);

        // R7: long reset drops overdrive, still a single event
        b0 = n_evt; bus_reset(500 * CYC);
        chk(n_evt == b0 + 1, "R1 single event across both thresholds", n_evt - b0, 1);
        chk(od_mode == 0, "R7 overdrive dropped by long reset", od_mode, 0);
        chk(pull_cnt == M_PL_REG, "R2 presence back at regular length", pull_cnt, M_PL_REG);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule